// File: doc/BRIEF.md
# PLL Unlock Phase-Error Detector

This block watches the up and down pulses coming out of a PLL phase comparator and measures how long each phase error lasts. A phase error is a run of consecutive clock cycles in which either pulse is high. The block compares each run against four fixed widths at the same time and raises a sticky flag for every width the run exceeds. The four widths correspond to roughly 0.55, 1.11, 2.22 and 3.33 microseconds when the block runs from a 7.2 MHz reference.

Software or a serial readout stage pulses a one-cycle latch strobe. The strobe copies the four flags into a registered status word and clears the flags in the same cycle. If a flag would be set in that same cycle, the set takes priority, so the event is reported at the next read and never lost. The bit order of the status word does not follow the threshold order: bit 3 holds the smallest width, and bits 0, 1 and 2 hold the other three in ascending order.

Top module: `unlock_phase_monitor`

## Requirements
- R1: While reset is high, the status word and all internal flags go to 0 at the next clock edge.
- R2: A run is counted in cycles where up is high, down is high, or both are high. A switch from up to down with no idle cycle between them continues the same run.
- R3: Status bit 3 is set by a run longer than 4 cycles. A run of exactly 4 cycles does not set it.
- R4: Status bit 0 is set by a run longer than 8 cycles. A run of exactly 8 cycles does not set it.
- R5: Status bit 1 is set by a run longer than 16 cycles. A run of exactly 16 cycles does not set it.
- R6: Status bit 2 is set by a run longer than 24 cycles. A run of exactly 24 cycles does not set it.
- R7: Any cycle with both up and down low restarts the run length. Two short runs separated by one idle cycle do not add up.
- R8: A set flag stays at 1 through idle time and later short runs until a latch strobe arrives.
- R9: A latch strobe copies the flags into the status word, which appears one cycle later. The same strobe clears the flags, so an immediate second strobe reads 0.
- R10: A flag whose set condition arrives in the same cycle as a latch strobe stays at 1. The strobe reports the old value, and the next strobe reports the flag.
- R11: Between strobes the status word holds its value, even while new flags are being set.
- R12: The run counter saturates. A run of several hundred cycles sets all four bits and does not wrap around into a false short run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that times the measurement |
| rst | input | 1 | Synchronous active-high reset |
| up_i | input | 1 | Phase comparator up pulse |
| dn_i | input | 1 | Phase comparator down pulse |
| latch_i | input | 1 | One-cycle read strobe: copies the flags to status_o and clears them |
| status_o | output | 4 | Latched unlock status, bit 3 = smallest width, bits 0..2 = ascending widths |

## Verification
The assertions assume that up_i, dn_i and latch_i are synchronous to clk and change only between rising edges. They also assume that latch_i is a single-cycle pulse that may coincide with any phase error. The bench drives every input on the falling edge and holds it for whole clock cycles. It always returns both comparator pulses to low before it issues a strobe, except in the one test that deliberately makes a set coincide with a strobe.

// File: rtl/upm_pkg.sv
package upm_pkg;
  localparam int unsigned NFLAG = 4;

  typedef logic [NFLAG-1:0] flag_vec_t;

  // Round a duration in ns to the nearest whole clock cycle.
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned ref_khz);
    return (ns * ref_khz + 500000) / 1000000;
  endfunction

  function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                          input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/upm_width_counter.sv
module upm_width_counter #(
  parameter int unsigned CNT_W   = 5,
  parameter int unsigned CNT_MAX = 25
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(CNT_MAX);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !active_i) begin
      cnt_q <= '0;
    end else if (cnt_q != SAT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/upm_sticky_flag.sv
module upm_sticky_flag #(
  parameter int unsigned CNT_W = 5,
  parameter int unsigned THR   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             clr_i,
  output logic             flag_o
);
  localparam logic [CNT_W-1:0] THR_V = CNT_W'(THR);

  logic hit;
  logic flag_q;

  // cnt_i is the number of active cycles already seen, so a hit in this
  // cycle means the run has reached THR+1 cycles.
  assign hit = active_i && (cnt_i >= THR_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= hit | (flag_q & ~clr_i);
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/unlock_phase_monitor.sv
module unlock_phase_monitor
  import upm_pkg::*;
#(
  parameter int unsigned REF_KHZ  = 7200,
  parameter int unsigned BIT0_NS  = 1110,
  parameter int unsigned BIT1_NS  = 2220,
  parameter int unsigned BIT2_NS  = 3330,
  parameter int unsigned BIT3_NS  = 550
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 up_i,
  input  logic                 dn_i,
  input  logic                 latch_i,
  output logic [NFLAG-1:0]     status_o
);
  localparam int unsigned THR_CYC [NFLAG] = '{
    ns_to_cycles(BIT0_NS, REF_KHZ),
    ns_to_cycles(BIT1_NS, REF_KHZ),
    ns_to_cycles(BIT2_NS, REF_KHZ),
    ns_to_cycles(BIT3_NS, REF_KHZ)
  };
  localparam int unsigned MAX_THR = max_of4(THR_CYC[0], THR_CYC[1], THR_CYC[2], THR_CYC[3]);
  localparam int unsigned CNT_MAX = MAX_THR + 1;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  logic             active;
  logic [CNT_W-1:0] run_cnt;
  flag_vec_t        flag_q;
  flag_vec_t        status_q;

  assign active = up_i | dn_i;

  upm_width_counter #(
    .CNT_W   (CNT_W),
    .CNT_MAX (CNT_MAX)
  ) width_i (
    .clk      (clk),
    .rst      (rst),
    .active_i (active),
    .cnt_o    (run_cnt)
  );

  for (genvar k = 0; k < NFLAG; k++) begin : g_flag
    upm_sticky_flag #(
      .CNT_W (CNT_W),
      .THR   (THR_CYC[k])
    ) flag_i (
      .clk      (clk),
      .rst      (rst),
      .active_i (active),
      .cnt_i    (run_cnt),
      .clr_i    (latch_i),
      .flag_o   (flag_q[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
    end else if (latch_i) begin
      status_q <= flag_q;
    end
  end

  assign status_o = status_q;
endmodule

// File: rtl/upm_checker.sv
module upm_checker (
  input logic       clk,
  input logic       rst,
  input logic       up_i,
  input logic       dn_i,
  input logic       latch_i,
  input logic [3:0] flag_q,
  input logic [3:0] status_o
);
  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (status_o == 4'd0 && flag_q == 4'd0));

  // R8: no flag drops without a strobe
  a_r8_flags_sticky: assert property (@(posedge clk) disable iff (rst)
    !latch_i |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  // R9: strobe copies the previous flags
  a_r9_latch_copy: assert property (@(posedge clk) disable iff (rst)
    latch_i |=> (status_o == $past(flag_q)));

  // R11
  a_r11_status_hold: assert property (@(posedge clk) disable iff (rst)
    !latch_i |=> $stable(status_o));

  // R7: an idle cycle never sets a flag
  a_r7_idle_no_set: assert property (@(posedge clk) disable iff (rst)
    (!up_i && !dn_i && !latch_i) |=> $stable(flag_q));

  // R9: a strobe during idle leaves no flag set
  a_r9_idle_clear: assert property (@(posedge clk) disable iff (rst)
    (latch_i && !up_i && !dn_i) |=> (flag_q == 4'd0));
endmodule

bind unlock_phase_monitor upm_checker chk_i (
  .clk      (clk),
  .rst      (rst),
  .up_i     (up_i),
  .dn_i     (dn_i),
  .latch_i  (latch_i),
  .flag_q   (flag_q),
  .status_o (status_o)
);

// File: tb/unlock_phase_monitor_tb_top.sv
module unlock_phase_monitor_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       up  = 1'b0;
  logic       dn  = 1'b0;
  logic       latch = 1'b0;
  logic [3:0] status;

  int n_vec  = 0;
  int n_miss = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  unlock_phase_monitor dut_i (
    .clk      (clk),
    .rst      (rst),
    .up_i     (up),
    .dn_i     (dn),
    .latch_i  (latch),
    .status_o (status)
  );

  // Bit 3: >4, bit 0: >8, bit 1: >16, bit 2: >24 cycles
  function automatic logic [3:0] exp_of(input int len);
    return {len > 4, len > 24, len > 16, len > 8};
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_miss++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // mode 0 up, 1 down, 2 both, 3 up then down alternating every 3 cycles
  task automatic pulse(input int len, input int mode);
    for (int i = 0; i < len; i++) begin
      case (mode)
        0: begin up = 1'b1; dn = 1'b0; end
        1: begin up = 1'b0; dn = 1'b1; end
        2: begin up = 1'b1; dn = 1'b1; end
        default: begin up = ((i / 3) % 2) == 0; dn = ((i / 3) % 2) != 0; end
      endcase
      @(negedge clk);
    end
    up = 1'b0;
    dn = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_status(output logic [3:0] v);
    latch = 1'b1;
    @(negedge clk);
    latch = 1'b0;
    v = status;
  endtask

  task automatic t_reset();
    logic [3:0] v;
    check("R1 status after reset", status, 4'd0);
    read_status(v);
    check("R1 flags after reset", v, 4'd0);
  endtask

  task automatic t_thresholds();
    int lens [8] = '{4, 5, 8, 9, 16, 17, 24, 25};
    logic [3:0] v;
    foreach (lens[j]) begin
      read_status(v);
      pulse(lens[j], 0);
      read_status(v);
      check($sformatf("R3 R4 R5 R6 run of %0d", lens[j]), v, exp_of(lens[j]));
    end
  endtask

  task automatic t_inputs();
    logic [3:0] v;
    read_status(v);
    pulse(9, 1);
    read_status(v);
    check("R2 down only, 9", v, 4'b1001);
    pulse(5, 2);
    read_status(v);
    check("R2 both high, 5", v, 4'b1000);
    pulse(17, 3);
    read_status(v);
    check("R2 up/down alternating, 17", v, 4'b1011);
  endtask

  task automatic t_gap();
    logic [3:0] v;
    read_status(v);
    pulse(4, 0);
    pulse(4, 1);
    read_status(v);
    check("R7 two runs of 4 split by idle", v, 4'b0000);
  endtask

  task automatic t_sticky();
    logic [3:0] v;
    read_status(v);
    pulse(9, 0);
    repeat (20) @(negedge clk);
    pulse(2, 0);
    read_status(v);
    check("R8 sticky through idle", v, 4'b1001);
    read_status(v);
    check("R9 second strobe reads cleared", v, 4'b0000);
  endtask

  task automatic t_hold();
    logic [3:0] v;
    read_status(v);
    pulse(5, 0);
    read_status(v);
    check("R11 initial read", v, 4'b1000);
    pulse(25, 0);
    repeat (3) @(negedge clk);
    check("R11 status held without strobe", status, 4'b1000);
    read_status(v);
    check("R9 new flags on strobe", v, 4'b1111);
  endtask

  task automatic t_collide();
    logic [3:0] v;
    read_status(v);
    up = 1'b1;
    repeat (4) @(negedge clk);
    latch = 1'b1;
    @(negedge clk);
    latch = 1'b0;
    v = status;
    up = 1'b0;
    @(negedge clk);
    check("R10 strobe reports old value", v, 4'b0000);
    read_status(v);
    check("R10 set beats clear", v, 4'b1000);
  endtask

  task automatic t_long();
    logic [3:0] v;
    read_status(v);
    pulse(300, 2);
    read_status(v);
    check("R12 long run all bits", v, 4'b1111);
    pulse(3, 0);
    read_status(v);
    check("R12 short run after saturation", v, 4'b0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_thresholds();
    t_inputs();
    t_gap();
    t_sticky();
    t_hold();
    t_collide();
    t_long();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_miss++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
    end
  end
endmodule